// File: doc/BRIEF.md
# Single-Line Bus Master with Presence Detect and Byte Transfer

This block is a memory-mapped master for a single open-drain 1-Wire line. Software talks to it through four byte-wide registers: a command register, a data register, an interrupt status register and an interrupt enable register. A command bit launches a bus reset with presence detection. Writing the data register sends one byte, least significant bit first, in timed slots. The line level sampled in each of those slots is gathered into a received byte and stored automatically when the transfer ends.

Every timing interval is counted in ticks of an external strobe, nominally one per microsecond, which a separate divider supplies. The block latches events into status flags. Reading the status register clears the event flags, and reading the data register clears receive-full. A level interrupt is raised whenever an enabled flag is set, and its active level can be programmed. A mode bit for the search accelerator is stored and brought out to that separate datapath.

The sequencer is a five-state machine. S_IDLE goes to S_RST_LOW on a reset command, or to S_SLOT on a data write. S_RST_LOW goes to S_RST_WAIT when its low interval ends, and S_RST_WAIT returns to S_IDLE when the release interval ends. S_SLOT goes to S_RECOVER at the end of the slot. S_RECOVER goes back to S_SLOT for the next bit, or to S_IDLE after the last bit.

Top module: `owm_master`

## Requirements
- R1: After reset the line is released, the interrupt enable register is 0x00 (so the output idles at 1, active-low), the status register reads 0x00 and the command register reads 0x00.
- R2: Writing offset 0 with bit 0 set while idle drives the line low for 480 ticks, then releases it for 625 ticks. Command register bit 0 reads 1 for the whole sequence.
- R3: Status bit 0 (presence event) is set 300 ticks after release. At the same moment status bit 1 is loaded with 1 if the line was never seen low on ticks 60 through 299 after release, and with 0 otherwise.
- R4: Writing offset 1 while idle sends that byte LSB first. Each bit takes a 60-tick slot followed by 5 recovery ticks. The line is driven low for the first 6 ticks of the slot for a 1, and for the first 60 ticks for a 0.
- R5: The line is sampled on tick 15 of each slot. When the last bit ends, the sampled byte is readable at offset 1, and status bits 2 (transmit done), 3 (receive full) and 5 (receive shift full) are set.
- R6: While a reset or a byte is in progress, writes to offset 1 and reset commands are ignored. The byte in flight and its result are unchanged.
- R7: Reading offset 2 clears status bits 0, 2 and 5. Bits 1 and 3 are unaffected.
- R8: Reading offset 1 clears status bit 3.
- R9: When a flag is set in the same cycle that a read would clear it, the flag ends up set.
- R10: The interrupt is active when any status bit 0, 2, 3 or 5 is set and its enable bit at the same position of offset 3 is set. Enable bit 1 selects polarity: 1 means active-high and 0 means active-low. The polarity holds even when every source is disabled.
- R11: Command bit 1 is stored on every write to offset 0. It drives search_en, reads back at command bit 1, and does not by itself start any bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing strobe, one per microsecond |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (read side effects) |
| rd_data | output | 8 | Read data for addr |
| dq_in | input | 1 | Sampled line level |
| dq_oe | output | 1 | 1 pulls the line low |
| irq_out | output | 1 | Interrupt with programmable polarity |
| search_en | output | 1 | Search accelerator mode bit |

## Verification
The hardest case to reach from the ports is a status read that lands in the very cycle the last recovery tick of a byte ends, so that the set of the transmit-done and shift-full flags collides with their clear. The bench follows its own tick count for the transfer. It waits until that count sits one tick before the end while the strobe is high for the coming edge, and only then raises the read strobe. It then checks that the read returned the old flags and that a second read finds them set. Presence detection is exercised with and without an emulated slave pulling the line low inside the window.

// File: rtl/owm_pkg.sv
package owm_pkg;
    localparam int A_CMD  = 0;
    localparam int A_DATA = 1;
    localparam int A_STAT = 2;
    localparam int A_IEN  = 3;

    localparam int F_PD   = 0;
    localparam int F_NONE = 1;
    localparam int F_TXE  = 2;
    localparam int F_RBF  = 3;
    localparam int F_RSF  = 5;
    localparam int E_POL  = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_LOW,
        S_RST_WAIT,
        S_SLOT,
        S_RECOVER
    } owm_state_e;
endpackage

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RST_LOW_T  = 480,
    parameter int RST_HIGH_T = 625,
    parameter int PD_HIGH_T  = 60,
    parameter int PD_LOW_T   = 240,
    parameter int SLOT_T     = 60,
    parameter int LOW1_T     = 6,
    parameter int LOW0_T     = 60,
    parameter int SAMPLE_T   = 15,
    parameter int REC_T      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_rst,
    input  logic              start_byte,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              dq_in,
    output logic              dq_oe,
    output logic              busy,
    output logic              rst_busy,
    output logic              pd_evt,
    output logic              pd_none,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int T_A   = (RST_LOW_T > RST_HIGH_T) ? RST_LOW_T : RST_HIGH_T;
    localparam int T_B   = (SLOT_T > REC_T) ? SLOT_T : REC_T;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    owm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              seen_q;
    logic              at_end;
    logic              in_win;
    logic              last_bit;

    always_comb begin
        unique case (state_q)
            S_RST_LOW:  limit = CNT_W'(RST_LOW_T - 1);
            S_RST_WAIT: limit = CNT_W'(RST_HIGH_T - 1);
            S_SLOT:     limit = CNT_W'(SLOT_T - 1);
            S_RECOVER:  limit = CNT_W'(REC_T - 1);
            default:    limit = '0;
        endcase
    end

    assign at_end   = tick && (cnt_q == limit);
    assign in_win   = (cnt_q >= CNT_W'(PD_HIGH_T)) && (cnt_q < CNT_W'(PD_HIGH_T + PD_LOW_T));
    assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_rst)       state_d = S_RST_LOW;
                else if (start_byte) state_d = S_SLOT;
            end
            S_RST_LOW:  if (at_end) state_d = S_RST_WAIT;
            S_RST_WAIT: if (at_end) state_d = S_IDLE;
            S_SLOT:     if (at_end) state_d = S_RECOVER;
            S_RECOVER:  if (at_end) state_d = last_bit ? S_IDLE : S_SLOT;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // interval counter, bit index and shift data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            seen_q <= 1'b0;
        end else begin
            if (state_d != state_q)
                cnt_q <= '0;
            else if (tick && state_q != S_IDLE)
                cnt_q <= cnt_q + 1'b1;

            if (state_q == S_IDLE && start_byte && !start_rst) begin
                bit_q <= '0;
                tx_q  <= tx_byte;
            end else if (state_q == S_RECOVER && state_d == S_SLOT) begin
                bit_q <= bit_q + 1'b1;
            end

            if (state_q == S_SLOT && tick && cnt_q == CNT_W'(SAMPLE_T))
                rx_q[bit_q] <= dq_in;

            if (state_q == S_IDLE && start_rst)
                seen_q <= 1'b0;
            else if (state_q == S_RST_WAIT && tick && in_win && !dq_in)
                seen_q <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        dq_oe     = 1'b0;
        busy      = 1'b1;
        rst_busy  = 1'b0;
        pd_evt    = 1'b0;
        byte_done = 1'b0;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_RST_LOW: begin
                dq_oe    = 1'b1;
                rst_busy = 1'b1;
            end
            S_RST_WAIT: begin
                rst_busy = 1'b1;
                pd_evt   = tick && (cnt_q == CNT_W'(PD_HIGH_T + PD_LOW_T - 1));
            end
            S_SLOT: dq_oe = tx_q[bit_q] ? (cnt_q < CNT_W'(LOW1_T)) : (cnt_q < CNT_W'(LOW0_T));
            S_RECOVER: byte_done = at_end && last_bit;
            default: busy = 1'b0;
        endcase
    end

    assign pd_none = ~(seen_q | ~dq_in);
    assign rx_byte = rx_q;
endmodule

// File: rtl/owm_regs.sv
module owm_regs
    import owm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              seq_busy,
    input  logic              rst_busy,
    input  logic              pd_evt,
    input  logic              pd_none,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              start_rst,
    output logic              start_byte,
    output logic              search_en,
    output logic              irq_out,
    output logic [DATA_W-1:0] rd_data
);
    logic              pd_q, none_q, txe_q, rbf_q, rsf_q, search_q;
    logic [DATA_W-1:0] rxbuf_q, ien_q, stat;
    logic              stat_rd, data_rd, irq_act;

    assign stat_rd    = rd_en && (addr == ADDR_W'(A_STAT));
    assign data_rd    = rd_en && (addr == ADDR_W'(A_DATA));
    assign start_rst  = wr_en && (addr == ADDR_W'(A_CMD)) && wr_data[0] && !seq_busy;
    assign start_byte = wr_en && (addr == ADDR_W'(A_DATA)) && !seq_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q     <= 1'b0;
            none_q   <= 1'b0;
            txe_q    <= 1'b0;
            rbf_q    <= 1'b0;
            rsf_q    <= 1'b0;
            search_q <= 1'b0;
            rxbuf_q  <= '0;
            ien_q    <= '0;
        end else begin
            pd_q  <= pd_evt    ? 1'b1 : (stat_rd ? 1'b0 : pd_q);
            txe_q <= byte_done ? 1'b1 : (stat_rd ? 1'b0 : txe_q);
            rsf_q <= byte_done ? 1'b1 : (stat_rd ? 1'b0 : rsf_q);
            rbf_q <= byte_done ? 1'b1 : (data_rd ? 1'b0 : rbf_q);
            if (pd_evt)    none_q  <= pd_none;
            if (byte_done) rxbuf_q <= rx_byte;
            if (wr_en && addr == ADDR_W'(A_CMD)) search_q <= wr_data[1];
            if (wr_en && addr == ADDR_W'(A_IEN)) ien_q    <= wr_data;
        end
    end

    always_comb begin
        stat         = '0;
        stat[F_PD]   = pd_q;
        stat[F_NONE] = none_q;
        stat[F_TXE]  = txe_q;
        stat[F_RBF]  = rbf_q;
        stat[F_RSF]  = rsf_q;
    end

    assign irq_act = (pd_q  & ien_q[F_PD])  | (txe_q & ien_q[F_TXE]) |
                     (rbf_q & ien_q[F_RBF]) | (rsf_q & ien_q[F_RSF]);
    assign irq_out   = ien_q[E_POL] ? irq_act : ~irq_act;
    assign search_en = search_q;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_W'(A_CMD): begin
                rd_data[0] = rst_busy;
                rd_data[1] = search_q;
            end
            ADDR_W'(A_DATA): rd_data = rxbuf_q;
            ADDR_W'(A_STAT): rd_data = stat;
            ADDR_W'(A_IEN):  rd_data = ien_q;
            default:         rd_data = '0;
        endcase
    end
endmodule

// File: rtl/owm_master.sv
module owm_master
    import owm_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int RST_LOW_T  = 480,
    parameter int RST_HIGH_T = 625,
    parameter int PD_HIGH_T  = 60,
    parameter int PD_LOW_T   = 240,
    parameter int SLOT_T     = 60,
    parameter int LOW1_T     = 6,
    parameter int LOW0_T     = 60,
    parameter int SAMPLE_T   = 15,
    parameter int REC_T      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dq_in,
    output logic              dq_oe,
    output logic              irq_out,
    output logic              search_en
);
    logic              start_rst, start_byte;
    logic              seq_busy, rst_busy, pd_evt, pd_none, byte_done;
    logic [DATA_W-1:0] rx_byte;

    owm_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .seq_busy  (seq_busy),
        .rst_busy  (rst_busy),
        .pd_evt    (pd_evt),
        .pd_none   (pd_none),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .start_rst (start_rst),
        .start_byte(start_byte),
        .search_en (search_en),
        .irq_out   (irq_out),
        .rd_data   (rd_data)
    );

    owm_seq #(
        .DATA_W    (DATA_W),
        .RST_LOW_T (RST_LOW_T),
        .RST_HIGH_T(RST_HIGH_T),
        .PD_HIGH_T (PD_HIGH_T),
        .PD_LOW_T  (PD_LOW_T),
        .SLOT_T    (SLOT_T),
        .LOW1_T    (LOW1_T),
        .LOW0_T    (LOW0_T),
        .SAMPLE_T  (SAMPLE_T),
        .REC_T     (REC_T)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_rst (start_rst),
        .start_byte(start_byte),
        .tx_byte   (wr_data),
        .dq_in     (dq_in),
        .dq_oe     (dq_oe),
        .busy      (seq_busy),
        .rst_busy  (rst_busy),
        .pd_evt    (pd_evt),
        .pd_none   (pd_none),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );
endmodule

// File: rtl/owm_master_sva.sv
module owm_master_sva
    import owm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              wr_rst_bit,
    input logic              rd_en,
    input logic [2:0]        rd_evt_bits,
    input logic              dq_oe,
    input logic              busy,
    input logic              rst_busy,
    input logic              pd_evt,
    input logic              byte_done
);
    // R1: no line drive while the sequencer is idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dq_oe);

    // R3: presence event only inside a reset sequence
    a_r3_pd_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        pd_evt |-> rst_busy);

    // R4: the last recovery tick returns the sequencer to idle
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !busy);

    // R6: a reset command during a byte does not start a reset
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rst_busy && wr_en && addr == ADDR_W'(A_CMD) && wr_rst_bit) |=> !rst_busy);

    // R7: event flags read back clear after a status read with no new event
    a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(A_STAT) && !pd_evt && !byte_done) |=>
        (addr != ADDR_W'(A_STAT) || rd_evt_bits == 3'b000));
endmodule

bind owm_master owm_master_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_rst_bit (wr_data[0]),
    .rd_en      (rd_en),
    .rd_evt_bits({rd_data[5], rd_data[2], rd_data[0]}),
    .dq_oe      (dq_oe),
    .busy       (seq_busy),
    .rst_busy   (rst_busy),
    .pd_evt     (pd_evt),
    .byte_done  (byte_done)
);

// File: tb/owm_master_bench.sv
module owm_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RL = 480, RH = 625, PH = 60, PL = 240;
    localparam int SL = 60, L1 = 6, L0 = 60, SM = 15, RC = 5;
    localparam int BT = SL + RC;
    localparam logic [2:0] A_CMD = 3'd0, A_DATA = 3'd1, A_STAT = 3'd2, A_IEN = 3'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       dq_in, dq_oe, irq_out, search_en;
    logic       tick;
    int         cyc = 0;
    int         total = 0, fails = 0;
    bit         done = 1'b0;

    // reference model state
    int         m_op = 0;  // 0 idle, 1 reset, 2 byte
    int         m_t = 0;
    logic [7:0] m_tx = 8'd0, m_rx = 8'd0, m_buf = 8'd0, m_ien = 8'd0, m_sl = 8'hFF;
    logic       m_seen = 1'b0, m_pd = 1'b0, m_none = 1'b0, m_txe = 1'b0;
    logic       m_rbf = 1'b0, m_rsf = 1'b0, m_search = 1'b0;
    logic       slave_present = 1'b0;
    logic       sl_low, e_oe, e_irq;
    string      oe_tag;

    initial forever #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tick = cyc[0];

    owm_master u_owm_master (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .dq_in(dq_in),
        .dq_oe(dq_oe), .irq_out(irq_out), .search_en(search_en)
    );

    // emulated slave and expected line drive
    always_comb begin
        sl_low = 1'b0;
        e_oe   = 1'b0;
        if (m_op == 1) begin
            e_oe   = (m_t < RL);
            sl_low = slave_present && (m_t >= RL + 70) && (m_t < RL + 200);
        end else if (m_op == 2 && m_t < 8 * BT) begin
            e_oe   = (m_t % BT) < (m_tx[m_t / BT] ? L1 : L0);
            sl_low = !m_sl[m_t / BT] && ((m_t % BT) < 30);
        end
        e_irq = ((m_pd & m_ien[0]) | (m_txe & m_ien[2]) | (m_rbf & m_ien[3]) | (m_rsf & m_ien[5]));
        if (!m_ien[1]) e_irq = !e_irq;
    end
    assign dq_in = ~(dq_oe | sl_low);

    // behavioural reference model
    logic       ev_pd, ev_byte, nnone, srd, drd;
    logic [7:0] rxn;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_op <= 0; m_t <= 0; m_pd <= 0; m_none <= 0; m_txe <= 0; m_rbf <= 0;
            m_rsf <= 0; m_search <= 0; m_ien <= 8'd0; m_buf <= 8'd0; m_seen <= 0;
        end else begin
            ev_pd = 0; ev_byte = 0; nnone = m_none; rxn = m_rx;
            if (m_op == 0) begin
                if (wr_en && addr == A_DATA) begin
                    m_op <= 2; m_t <= 0; m_tx <= wr_data;
                end else if (wr_en && addr == A_CMD && wr_data[0]) begin
                    m_op <= 1; m_t <= 0; m_seen <= 0;
                end
            end else if (tick) begin
                m_t <= m_t + 1;
                if (m_op == 2) begin
                    if ((m_t % BT) == SM) rxn[m_t / BT] = dq_in;
                    if (m_t + 1 == 8 * BT) begin m_op <= 0; ev_byte = 1; end
                end else begin
                    if (m_t >= RL + PH && m_t < RL + PH + PL && !dq_in) m_seen <= 1;
                    if (m_t == RL + PH + PL - 1) begin ev_pd = 1; nnone = !(m_seen || !dq_in); end
                    if (m_t + 1 == RL + RH) m_op <= 0;
                end
            end
            m_rx <= rxn;
            m_none <= nnone;
            if (wr_en && addr == A_CMD) m_search <= wr_data[1];
            if (wr_en && addr == A_IEN) m_ien <= wr_data;
            srd = rd_en && addr == A_STAT;
            drd = rd_en && addr == A_DATA;
            m_pd  <= ev_pd   ? 1'b1 : (srd ? 1'b0 : m_pd);
            m_txe <= ev_byte ? 1'b1 : (srd ? 1'b0 : m_txe);
            m_rsf <= ev_byte ? 1'b1 : (srd ? 1'b0 : m_rsf);
            m_rbf <= ev_byte ? 1'b1 : (drd ? 1'b0 : m_rbf);
            if (ev_byte) m_buf <= rxn;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            oe_tag = (m_op == 1) ? "R2 line" : ((m_op == 2) ? "R4 line" : "R1 line");
            chk(oe_tag, int'(dq_oe), int'(e_oe));
            chk("R10 irq", int'(irq_out), int'(e_irq));
            chk("R11 search", int'(search_en), int'(m_search));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 chk(tag, int'(rd_data), int'(exp));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_op != 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 chk("R1 irq idle", int'(irq_out), 1);
        chk("R1 line", int'(dq_oe), 0);
        rst_n = 1'b1;
        rd(A_STAT, 8'h00, "R1 status");
        rd(A_CMD, 8'h00, "R1 cmd");

        wr(A_IEN, 8'h03);
        #1 chk("R10 active high idle", int'(irq_out), 0);
        slave_present = 1'b1;
        wr(A_CMD, 8'h01);
        rd(A_CMD, 8'h01, "R2 busy");
        wait_idle();
        chk("R3 irq on presence", int'(irq_out), 1);
        rd(A_STAT, 8'h01, "R3 slave seen");
        #1 chk("R7 irq after read", int'(irq_out), 0);

        slave_present = 1'b0;
        wr(A_CMD, 8'h01);
        wait_idle();
        rd(A_STAT, 8'h03, "R3 no slave");

        wr(A_IEN, 8'h2E);
        m_sl = 8'hFF;
        wr(A_DATA, 8'hA5);
        wait_idle();
        rd(A_STAT, 8'h2E, "R5 flags");
        rd(A_STAT, 8'h0A, "R7 rbf kept");
        rd(A_DATA, 8'hA5, "R5 rx byte");
        rd(A_STAT, 8'h02, "R8 rbf clear");

        m_sl = 8'h3C;
        wr(A_DATA, 8'hFF);
        repeat (50) @(negedge clk);
        wr(A_DATA, 8'h00);
        wr(A_CMD, 8'h01);
        rd(A_CMD, 8'h00, "R6 no reset");
        wait_idle();
        rd(A_DATA, 8'h3C, "R6 byte kept");
        rd(A_STAT, 8'h26, "R8 after data read");

        // R9: status read in the cycle the byte completes
        m_sl = 8'hFF;
        wr(A_DATA, 8'h5A);
        forever begin
            @(negedge clk);
            if (m_op == 2 && m_t == 8 * BT - 1 && tick) break;
        end
        addr = A_STAT; rd_en = 1'b1;
        #1 chk("R9 pre-event read", int'(rd_data), 8'h02);
        @(negedge clk);
        rd_en = 1'b0;
        rd(A_STAT, 8'h2E, "R9 set wins");
        rd(A_STAT, 8'h0A, "R7 only rbf left");
        #1 chk("R7 irq from rbf", int'(irq_out), 1);
        rd(A_DATA, 8'h5A, "R8 data");
        #1 chk("R8 irq clear", int'(irq_out), 0);

        wr(A_IEN, 8'h04);
        #1 chk("R10 active low idle", int'(irq_out), 1);
        wr(A_DATA, 8'h00);
        wait_idle();
        chk("R10 active low asserted", int'(irq_out), 0);
        rd(A_STAT, 8'h2E, "R10 status");
        #1 chk("R10 released", int'(irq_out), 1);
        wr(A_IEN, 8'h02);
        #1 chk("R10 polarity kept all off", int'(irq_out), 0);
        rd(A_DATA, 8'h00, "R5 zero byte");

        wr(A_CMD, 8'h02);
        #1 chk("R11 search on", int'(search_en), 1);
        rd(A_CMD, 8'h02, "R11 readback");
        repeat (10) @(negedge clk);
        chk("R11 no bus activity", int'(dq_oe), 0);
        wr(A_CMD, 8'h00);
        #1 chk("R11 search off", int'(search_en), 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule